// File: doc/BRIEF.md
# Standby Entry and Wake Controller

This block sequences the deep low-power state of a small microcontroller. When the CPU issues a sleep strobe and the configuration selects standby (standby select set, low-speed operation off, timer-only mode off), the controller stops the system clock, places the general I/O in high impedance and tells one designated port to hold its last pin state. Register and memory contents survive because only the clock is removed.

The chip leaves standby in one of two ways. An interrupt request that is individually enabled and not blocked by the global mask starts a settling interval, counted on the raw oscillator clock, whose length comes from a 3-bit select. When the count expires the clock returns, the speed select takes the configured medium/high choice and a one-cycle interrupt-exception pulse is issued. A low level on the reset pin instead restores the clock at once, overrides any pending interrupt wake, and a reset-exception pulse follows when the pin returns high.

Top module: `standby_wake_ctrl`

## Requirements
- R1: A sleep strobe sampled while cfg_stby=1, cfg_lowspd=0 and cfg_tmode=0 moves the block to standby on that clock edge: after it sys_clk_en=0, io_hiz=1 and port_hold=1.
- R2: A sleep strobe with any other combination of those three bits has no effect: sys_clk_en stays 1 and io_hiz stays 0.
- R3: Throughout standby and the settling interval sys_clk_en=0, io_hiz=1 and port_hold=1.
- R4: In standby an interrupt request does not wake the block when irq_mask=1 or when its bit in irq_en is 0; the block stays in standby with no exception pulse.
- R5: An interrupt request with its irq_en bit set and irq_mask=0 starts the settling interval; counting the wake edge as edge 1, irq_exc_start is high after edge N+1, where N is the selected settling count, and sys_clk_en stays 0 until then.
- R6: The settling count N for cfg_settle_sel 0..4 is 8192, 16384, 32768, 65536, 131072; for 5, 6, 7 it is 1024, 128, 16.
- R7: At the end of the settling interval sys_clk_en returns to 1 and io_hiz to 0 in the same cycle that irq_exc_start is high, and irq_exc_start lasts exactly one cycle.
- R8: After an interrupt wake speed_med equals cfg_medspd (1 = medium speed, 0 = high speed).
- R9: A low res_n in standby or during settling restores sys_clk_en=1 and io_hiz=0 after the next edge; rst_exc_start pulses for one cycle after the first edge that sees res_n high again, and speed_med is 0.
- R10: When res_n is low on the same edge as a valid interrupt wake, or during settling, the reset path wins and no irq_exc_start pulse is ever issued for that wake.
- R11: Synchronous reset rst leaves the block running: sys_clk_en=1, io_hiz=0, port_hold=0, speed_med=0 and both exception pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| sleep_req | input | 1 | Sleep strobe from the CPU |
| cfg_stby | input | 1 | Standby select |
| cfg_lowspd | input | 1 | Low-speed operation on |
| cfg_tmode | input | 1 | Timer-only mode |
| cfg_medspd | input | 1 | Resume at medium speed after interrupt wake |
| cfg_settle_sel | input | 3 | Settling interval select |
| irq_req | input | NUM_IRQ | Interrupt requests |
| irq_en | input | NUM_IRQ | Per-interrupt enables |
| irq_mask | input | 1 | Global interrupt mask |
| res_n | input | 1 | Reset pin, active low |
| sys_clk_en | output | 1 | System clock enable |
| io_hiz | output | 1 | General I/O high-impedance control |
| port_hold | output | 1 | Designated port holds its last pin state |
| speed_med | output | 1 | 1 = medium speed, 0 = high speed |
| irq_exc_start | output | 1 | One-cycle interrupt-exception start |
| rst_exc_start | output | 1 | One-cycle reset-exception start |

## Verification
The bench walks every combination of the three entry bits, since a decoder that ignored one bit would enter standby from timer-only or low-speed configurations. It measures the settling interval to the exact cycle for several select codes, which exposes off-by-one counters and a swapped table entry. It blocks wakes by the mask and by a cleared enable, which a design that ORs raw requests would not honour, and it drops the reset pin both together with an interrupt and in the middle of settling, where a design with the wrong priority would later emit a stray interrupt-exception pulse.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_WAKE    = 2'd3
    } pm_state_t;

    typedef struct packed {
        logic             stby_sel;
        logic             low_spd;
        logic             timer_mode;
        logic             med_spd;
        logic [SEL_W-1:0] settle_sel;
    } pm_cfg_t;

    // Settling length in oscillator cycles for a select code.
    function automatic int unsigned settle_cycles(input logic [SEL_W-1:0] sel,
                                                  input int unsigned base_log);
        int unsigned n;
        case (sel)
            3'd5:    n = 32'd1024;
            3'd6:    n = 32'd128;
            3'd7:    n = 32'd16;
            default: n = 32'd1 << (base_log + 32'(sel));
        endcase
        return n;
    endfunction

endpackage

// File: rtl/stby_decode.sv
module stby_decode #(
    parameter int NUM_IRQ = 8
) (
    input  logic               sleep_req,
    input  logic               stby_sel,
    input  logic               low_spd,
    input  logic               timer_mode,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_mask,
    output logic               enter_ok,
    output logic               wake_ok
);
    logic [NUM_IRQ-1:0] live;

    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_live
            assign live[g] = irq_req[g] & irq_en[g];
        end
    endgenerate

    always_comb begin
        enter_ok = sleep_req & stby_sel & ~low_spd & ~timer_mode;
        wake_ok  = (|live) & ~irq_mask;
    end

    // R4
    always_comb begin
        mask_blocks_chk: assert (!(irq_mask && wake_ok));
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer
    import stby_pkg::*;
#(
    parameter int CNT_W    = 18,
    parameter int BASE_LOG = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             abort,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (abort) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(settle_cycles(sel, BASE_LOG) - 32'd1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run_q && (cnt_q == '0);

    // R5
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != '0 && !abort && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R7
    done_once_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
    import stby_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enter_ok,
    input  logic wake_ok,
    input  logic res_n,
    input  logic timer_done,
    input  logic med_spd,
    output logic timer_load,
    output logic timer_abort,
    output logic sys_clk_en,
    output logic io_hiz,
    output logic port_hold,
    output logic speed_med,
    output logic irq_exc_start,
    output logic rst_exc_start
);
    pm_state_t state_q, state_d;
    logic      pend_q, pend_d;
    logic      spd_q, spd_d;
    logic      rexc_q, rexc_d;

    always_comb begin
        state_d     = state_q;
        pend_d      = pend_q;
        spd_d       = spd_q;
        rexc_d      = 1'b0;
        timer_load  = 1'b0;
        timer_abort = 1'b0;
        case (state_q)
            ST_ACTIVE: begin
                if (pend_q && res_n) begin
                    rexc_d = 1'b1;
                    pend_d = 1'b0;
                end else if (enter_ok && res_n && !pend_q) begin
                    state_d = ST_STANDBY;
                end
            end
            ST_STANDBY: begin
                if (!res_n) begin
                    state_d = ST_ACTIVE;
                    pend_d  = 1'b1;
                    spd_d   = 1'b0;
                end else if (wake_ok) begin
                    state_d    = ST_SETTLE;
                    timer_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!res_n) begin
                    state_d     = ST_ACTIVE;
                    pend_d      = 1'b1;
                    spd_d       = 1'b0;
                    timer_abort = 1'b1;
                end else if (timer_done) begin
                    state_d = ST_WAKE;
                    spd_d   = med_spd;
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACTIVE;
            pend_q  <= 1'b0;
            spd_q   <= 1'b0;
            rexc_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            spd_q   <= spd_d;
            rexc_q  <= rexc_d;
        end
    end

    always_comb begin
        sys_clk_en    = (state_q == ST_ACTIVE) || (state_q == ST_WAKE);
        io_hiz        = !sys_clk_en;
        port_hold     = !sys_clk_en;
        speed_med     = spd_q;
        irq_exc_start = (state_q == ST_WAKE);
        rst_exc_start = rexc_q;
    end

    // R1
    entry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && !enter_ok) |=> (state_q == ST_ACTIVE || state_q == ST_WAKE));
    // R4
    hold_standby_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STANDBY && !wake_ok && res_n) |=> (state_q == ST_STANDBY));
    // R10
    pin_priority_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_STANDBY || state_q == ST_SETTLE) && !res_n) |=> (state_q == ST_ACTIVE && !irq_exc_start));
    // R9
    rst_exc_chk: assert property (@(posedge clk) disable iff (rst)
        rst_exc_start |-> ($past(res_n) && sys_clk_en));
    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_exc_start |=> !irq_exc_start);
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
    import stby_pkg::*;
#(
    parameter int NUM_IRQ  = 8,
    parameter int BASE_LOG = 13,
    parameter int CNT_W    = BASE_LOG + 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic               cfg_stby,
    input  logic               cfg_lowspd,
    input  logic               cfg_tmode,
    input  logic               cfg_medspd,
    input  logic [2:0]         cfg_settle_sel,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_mask,
    input  logic               res_n,
    output logic               sys_clk_en,
    output logic               io_hiz,
    output logic               port_hold,
    output logic               speed_med,
    output logic               irq_exc_start,
    output logic               rst_exc_start
);
    pm_cfg_t cfg;
    logic    enter_ok, wake_ok, t_load, t_abort, t_done;

    assign cfg = '{stby_sel: cfg_stby, low_spd: cfg_lowspd, timer_mode: cfg_tmode,
                   med_spd: cfg_medspd, settle_sel: cfg_settle_sel};

    stby_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
        .sleep_req (sleep_req),
        .stby_sel  (cfg.stby_sel),
        .low_spd   (cfg.low_spd),
        .timer_mode(cfg.timer_mode),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .irq_mask  (irq_mask),
        .enter_ok  (enter_ok),
        .wake_ok   (wake_ok)
    );

    settle_timer #(.CNT_W(CNT_W), .BASE_LOG(BASE_LOG)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .abort(t_abort),
        .sel  (cfg.settle_sel),
        .done (t_done)
    );

    standby_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .enter_ok     (enter_ok),
        .wake_ok      (wake_ok),
        .res_n        (res_n),
        .timer_done   (t_done),
        .med_spd      (cfg.med_spd),
        .timer_load   (t_load),
        .timer_abort  (t_abort),
        .sys_clk_en   (sys_clk_en),
        .io_hiz       (io_hiz),
        .port_hold    (port_hold),
        .speed_med    (speed_med),
        .irq_exc_start(irq_exc_start),
        .rst_exc_start(rst_exc_start)
    );

    // R3
    standby_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !sys_clk_en |-> (io_hiz && port_hold && !irq_exc_start));
endmodule

// File: tb/standby_wake_ctrl_tb.sv
module standby_wake_ctrl_tb;
    localparam int NI = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 0, cfg_stby = 0, cfg_lowspd = 0, cfg_tmode = 0, cfg_medspd = 0;
    logic [2:0] cfg_settle_sel = 3'd7;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic irq_mask = 0, res_n = 1;
    logic sys_clk_en, io_hiz, port_hold, speed_med, irq_exc_start, rst_exc_start;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    standby_wake_ctrl #(.NUM_IRQ(NI)) u_dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .cfg_stby(cfg_stby),
        .cfg_lowspd(cfg_lowspd), .cfg_tmode(cfg_tmode), .cfg_medspd(cfg_medspd),
        .cfg_settle_sel(cfg_settle_sel), .irq_req(irq_req), .irq_en(irq_en),
        .irq_mask(irq_mask), .res_n(res_n), .sys_clk_en(sys_clk_en), .io_hiz(io_hiz),
        .port_hold(port_hold), .speed_med(speed_med), .irq_exc_start(irq_exc_start),
        .rst_exc_start(rst_exc_start)
    );

    // {stby, lowspd, tmode, expect_entry}
    localparam logic [3:0] VEC [8] = '{4'b0000, 4'b0010, 4'b0100, 4'b0110,
                                       4'b1001, 4'b1010, 4'b1100, 4'b1110};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic enter_standby();
        @(negedge clk);
        cfg_stby = 1; cfg_lowspd = 0; cfg_tmode = 0; sleep_req = 1;
        tick();
        @(negedge clk);
        sleep_req = 0;
        chk(io_hiz && !sys_clk_en && port_hold, "R1 entry", {29'd0, sys_clk_en, io_hiz, port_hold}, 3);
    endtask

    task automatic wake_by_pin();
        @(negedge clk);
        res_n = 0;
        tick();
        chk(sys_clk_en && !io_hiz, "R9 clock back", sys_clk_en, 1);
        chk(!irq_exc_start, "R10 no irq pulse", irq_exc_start, 0);
        @(negedge clk);
        res_n = 1;
        tick();
        chk(rst_exc_start && !speed_med, "R9 reset pulse", {30'd0, rst_exc_start, speed_med}, 2);
        tick();
        chk(!rst_exc_start, "R9 pulse width", rst_exc_start, 0);
    endtask

    task automatic irq_wake(input logic [2:0] sel, input logic med, input int n);
        int k;
        bit gap_ok;
        @(negedge clk);
        cfg_settle_sel = sel; cfg_medspd = med; irq_mask = 0;
        irq_en = 8'h10; irq_req = 8'h10;
        k = 0; gap_ok = 1;
        while (k < n + 50) begin
            tick();
            k++;
            if (irq_exc_start) break;
            if (sys_clk_en || !io_hiz || !port_hold) gap_ok = 0;
            if (k == 1) irq_req = '0;
        end
        chk(k == n + 1, "R5/R6 settle length", k, n + 1);
        chk(gap_ok, "R3 gated during settle", gap_ok, 1);
        chk(sys_clk_en && !io_hiz, "R7 clock on with pulse", sys_clk_en, 1);
        chk(speed_med == med, "R8 speed select", speed_med, med);
        tick();
        chk(!irq_exc_start && sys_clk_en, "R7 single pulse", irq_exc_start, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        @(negedge clk);
        rst = 0;
        #1;
        // R11
        chk(sys_clk_en && !io_hiz && !port_hold && !speed_med && !irq_exc_start && !rst_exc_start,
            "R11 reset state", {26'd0, sys_clk_en, io_hiz, port_hold, speed_med, irq_exc_start, rst_exc_start}, 32);

        // R1 / R2 table of entry conditions
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {cfg_stby, cfg_lowspd, cfg_tmode} = VEC[i][3:1];
            sleep_req = 1;
            tick();
            @(negedge clk);
            sleep_req = 0;
            chk(io_hiz == VEC[i][0] && sys_clk_en == !VEC[i][0], VEC[i][0] ? "R1 vec" : "R2 vec",
                io_hiz, VEC[i][0]);
            if (VEC[i][0]) wake_by_pin();
        end

        // R4 masked and disabled interrupts
        enter_standby();
        @(negedge clk);
        irq_mask = 1; irq_en = 8'hFF; irq_req = 8'h03;
        repeat (6) tick();
        chk(io_hiz && !irq_exc_start, "R4 masked", io_hiz, 1);
        @(negedge clk);
        irq_mask = 0; irq_en = 8'hFC;
        repeat (6) tick();
        chk(io_hiz && !irq_exc_start, "R4 disabled", io_hiz, 1);
        @(negedge clk);
        irq_req = '0;
        wake_by_pin();

        // R5 / R6 / R7 / R8 interrupt wakes at several settle codes
        enter_standby(); irq_wake(3'd7, 1'b1, 16);
        enter_standby(); irq_wake(3'd6, 1'b0, 128);
        enter_standby(); irq_wake(3'd5, 1'b1, 1024);
        enter_standby(); irq_wake(3'd0, 1'b0, 8192);

        // R10 simultaneous reset pin and interrupt
        enter_standby();
        @(negedge clk);
        cfg_medspd = 1; irq_en = 8'h01; irq_req = 8'h01; res_n = 0;
        tick();
        chk(sys_clk_en && !irq_exc_start, "R10 pin wins", irq_exc_start, 0);
        @(negedge clk);
        irq_req = '0; res_n = 1;
        tick();
        chk(rst_exc_start && !speed_med, "R10 reset pulse", rst_exc_start, 1);

        // R10 reset pin during settling
        enter_standby();
        @(negedge clk);
        cfg_settle_sel = 3'd7; irq_req = 8'h01;
        tick();
        @(negedge clk);
        irq_req = '0;
        repeat (3) tick();
        chk(!sys_clk_en, "R3 settling gated", sys_clk_en, 0);
        begin
            bit seen;
            seen = 0;
            @(negedge clk);
            res_n = 0;
            tick();
            chk(sys_clk_en, "R9 abort settle", sys_clk_en, 1);
            @(negedge clk);
            res_n = 1;
            for (int j = 0; j < 40; j++) begin
                tick();
                if (irq_exc_start) seen = 1;
            end
            chk(!seen, "R10 abandoned wake", seen, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule